// File: doc/BRIEF.md
# Interlock Protection Logic with Latch and Delay Timers

This block is a fixed protection network for a slow industrial process. It reads a set of single-bit sensor and command lines and drives three binary commands. A trip memory is armed by a vibration signal that has been confirmed by an on-delay, or directly by an overheat signal. A veto line can hold the arming back. The memory clears only when two independent clear commands are both asserted. If arming and clearing are active together, arming wins.

The trip output shows the memory state directly. An alarm output follows the memory but is stretched by an off-delay. A short re-trip inside the stretch window therefore keeps the alarm on without a gap. A second, independent path raises a sequence output after any of several channel requests has stayed present, with no inhibit, for a long on-delay.

Every delay is a number of ticks times a number of clock cycles per tick. The parameters for the ticks and for the cycles per tick are separate. A synchronous reset clears the memory and all counters. Nothing in the network feeds back upstream.

Top module: `prot_logic_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the memory and every timer counter are cleared. After that edge, `trip_o`, `horn_o` and `seq_o` all read 0.
- R2: The arm condition is (confirmed vibration OR `heat_i`) AND NOT `veto_i`. When it is true at a clock edge, `trip_o` reads 1 after that edge.
- R3: The clear condition is `clr_a_i` AND `clr_b_i`. With the arm condition false, the clear condition at an edge makes `trip_o` read 0 after that edge. One clear command alone leaves `trip_o` unchanged.
- R4: Arming dominates. When the arm and clear conditions are both true at an edge, `trip_o` reads 1 after it.
- R5: `trip_o` is the memory state itself, with no delay and no gating between them.
- R6: Vibration counts as confirmed only after `vib_i` has been high on VIB_TICKS*CYC_PER_TICK consecutive rising edges. If `vib_i` rises before edge 1 and nothing else arms, `trip_o` is still 0 after edge VIB_TICKS*CYC_PER_TICK and reads 1 after the next edge.
- R7: If `vib_i` drops before the confirmation completes, the vibration count restarts from zero on the next high period.
- R8: `horn_o` reads 1 in every cycle in which `trip_o` reads 1. After the memory clears at edge f, `horn_o` stays 1 through edge f+HOLD_TICKS*CYC_PER_TICK-1 and reads 0 after edge f+HOLD_TICKS*CYC_PER_TICK.
- R9: If the memory sets again while the hold window is running, `horn_o` shows no gap. The next clear then starts a full-length hold window.
- R10: The sequence request is (OR of all `chan_i` bits) AND NOT `inhibit_i`. `seq_o` reads 1 after the request has been true on SEQ_TICKS*CYC_PER_TICK consecutive edges. It reads 0 as soon as the request drops.
- R11: A sequence request that drops before its delay completes restarts its count from zero.
- R12: While `veto_i` is high and vibration is not yet confirmed, `heat_i` cannot set the memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vib_i | input | 1 | Vibration sensor, arms through the on-delay |
| heat_i | input | 1 | Overheat sensor, arms directly |
| veto_i | input | 1 | Blocks arming while high |
| clr_a_i | input | 1 | First clear command |
| clr_b_i | input | 1 | Second clear command |
| chan_i | input | CHAN_N | Sequence request channels, ORed together |
| inhibit_i | input | 1 | Blocks the sequence request while high |
| trip_o | output | 1 | Trip memory state |
| horn_o | output | 1 | Trip state stretched by the off-delay |
| seq_o | output | 1 | Sequence request after its on-delay |

## Verification
The bench builds the block with CYC_PER_TICK=2, VIB_TICKS=5, HOLD_TICKS=3 and SEQ_TICKS=10. The confirmation, hold and sequence windows are then 10, 6 and 20 cycles long. Each window can be run to expiry, interrupted, and restarted within a few hundred cycles. Because the prescale value is above one, an error that drops the tick multiplication, or that is off by one edge, changes the exact cycle in which an output moves, and the bench samples that cycle.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic { TK_ON_DELAY = 1'b0, TK_OFF_DELAY = 1'b1 } timer_kind_e;
endpackage

// File: rtl/pl_set_latch.sv
module pl_set_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic state_q;

  always_ff @(posedge clk) begin
    if (rst)        state_q <= 1'b0;
    else if (set_i) state_q <= 1'b1;
    else if (clr_i) state_q <= 1'b0;
  end

  assign q_o = state_q;

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst) set_i |=> q_o);
  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst) (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/pl_delay_timer.sv
module pl_delay_timer #(
  parameter prot_pkg::timer_kind_e KIND = prot_pkg::TK_ON_DELAY,
  parameter int unsigned TICKS        = 10,
  parameter int unsigned CYC_PER_TICK = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_i,
  output logic q_o
);
  localparam int unsigned LIMIT = TICKS * CYC_PER_TICK;
  localparam int unsigned W     = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt_q;

  generate
    if (KIND == prot_pkg::TK_ON_DELAY) begin : g_on
      always_ff @(posedge clk) begin
        if (rst || !in_i)       cnt_q <= '0;
        else if (cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
      end
      assign q_o = in_i && (cnt_q == LIM_V);

      // R6
      on_wait_chk: assert property (@(posedge clk) disable iff (rst) $rose(q_o) |-> $past(in_i));
    end else begin : g_off
      always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (in_i)          cnt_q <= LIM_V;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign q_o = in_i || (cnt_q != '0);

      // R8
      hold_start_chk: assert property (@(posedge clk) disable iff (rst) $fell(in_i) |-> q_o);
    end
  endgenerate
endmodule

// File: rtl/prot_logic_core.sv
module prot_logic_core #(
  parameter int unsigned CHAN_N       = 3,
  parameter int unsigned CYC_PER_TICK = 50000,
  parameter int unsigned VIB_TICKS    = 5000,
  parameter int unsigned HOLD_TICKS   = 3000,
  parameter int unsigned SEQ_TICKS    = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vib_i,
  input  logic              heat_i,
  input  logic              veto_i,
  input  logic              clr_a_i,
  input  logic              clr_b_i,
  input  logic [CHAN_N-1:0] chan_i,
  input  logic              inhibit_i,
  output logic              trip_o,
  output logic              horn_o,
  output logic              seq_o
);
  logic vib_ok, arm, disarm, mem_q, seq_req;

  pl_delay_timer #(.KIND(prot_pkg::TK_ON_DELAY), .TICKS(VIB_TICKS), .CYC_PER_TICK(CYC_PER_TICK))
    u_vib_dly (.clk(clk), .rst(rst), .in_i(vib_i), .q_o(vib_ok));

  always_comb begin
    arm     = (vib_ok || heat_i) && !veto_i;
    disarm  = clr_a_i && clr_b_i;
    seq_req = (|chan_i) && !inhibit_i;
  end

  pl_set_latch u_mem (.clk(clk), .rst(rst), .set_i(arm), .clr_i(disarm), .q_o(mem_q));

  pl_delay_timer #(.KIND(prot_pkg::TK_OFF_DELAY), .TICKS(HOLD_TICKS), .CYC_PER_TICK(CYC_PER_TICK))
    u_hold (.clk(clk), .rst(rst), .in_i(mem_q), .q_o(horn_o));

  pl_delay_timer #(.KIND(prot_pkg::TK_ON_DELAY), .TICKS(SEQ_TICKS), .CYC_PER_TICK(CYC_PER_TICK))
    u_seq_dly (.clk(clk), .rst(rst), .in_i(seq_req), .q_o(seq_o));

  assign trip_o = mem_q;

  // R8
  horn_covers_chk: assert property (@(posedge clk) disable iff (rst) trip_o |-> horn_o);
  // R12
  veto_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (veto_i && !trip_o && !disarm) |=> !trip_o);
  // R10
  seq_drop_chk: assert property (@(posedge clk) disable iff (rst) !seq_req |-> !seq_o);
endmodule

// File: tb/prot_logic_core_tb.sv
module prot_logic_core_tb;
  localparam int CPT = 2;
  localparam int LV  = 5 * CPT;
  localparam int LH  = 3 * CPT;
  localparam int LS  = 10 * CPT;

  logic clk = 1'b0;
  logic rst = 1'b1, vib = 1'b0, heat = 1'b0, veto = 1'b0, ca = 1'b0, cb = 1'b0, inh = 1'b0;
  logic [2:0] ch = 3'b000;
  logic trip, horn, seq;

  logic s_rst = 1'b1, s_vib = 1'b0, s_heat = 1'b0, s_veto = 1'b0, s_ca = 1'b0, s_cb = 1'b0, s_inh = 1'b0;
  logic [2:0] s_ch = 3'b000;

  typedef struct { logic t; logic h; logic s; string tag; } exp_t;
  exp_t exp_q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prot_logic_core #(.CHAN_N(3), .CYC_PER_TICK(CPT), .VIB_TICKS(5), .HOLD_TICKS(3), .SEQ_TICKS(10)) u_dut (
    .clk(clk), .rst(rst), .vib_i(vib), .heat_i(heat), .veto_i(veto),
    .clr_a_i(ca), .clr_b_i(cb), .chan_i(ch), .inhibit_i(inh),
    .trip_o(trip), .horn_o(horn), .seq_o(seq));

  task automatic stage(input logic v, h, ve, a, b, input logic [2:0] c, input logic i);
    s_vib = v; s_heat = h; s_veto = ve; s_ca = a; s_cb = b; s_ch = c; s_inh = i;
  endtask

  // apply staged inputs at a falling edge; expectation is for after the next rising edge
  task automatic cyc(input logic et, eh, es, input string tag);
    exp_t e;
    @(negedge clk);
    rst = s_rst; vib = s_vib; heat = s_heat; veto = s_veto;
    ca = s_ca; cb = s_cb; ch = s_ch; inh = s_inh;
    e.t = et; e.h = eh; e.s = es; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        total++;
        if (trip !== e.t || horn !== e.h || seq !== e.s) begin
          bad++;
          $display("FAIL %s: trip/horn/seq got %b%b%b expected %b%b%b",
                   e.tag, trip, horn, seq, e.t, e.h, e.s);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not end, got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    // R1 reset
    s_rst = 1'b1;
    stage(1, 1, 0, 0, 0, 3'b111, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, "R1");
    s_rst = 1'b0;
    stage(0, 0, 0, 0, 0, 3'b000, 0);
    cyc(0, 0, 0, "R1");

    // R6/R5: vibration confirmation
    stage(1, 0, 0, 0, 0, 3'b000, 0);
    for (int i = 1; i <= LV; i++) cyc(0, 0, 0, "R6");
    cyc(1, 1, 0, "R6");
    cyc(1, 1, 0, "R5");
    // R8: clear, then hold window
    stage(0, 0, 0, 1, 1, 3'b000, 0);
    cyc(0, 1, 0, "R8");
    stage(0, 0, 0, 0, 0, 3'b000, 0);
    for (int j = 1; j < LH; j++) cyc(0, 1, 0, "R8");
    cyc(0, 0, 0, "R8");
    cyc(0, 0, 0, "R8");

    // R12: veto blocks heat
    stage(0, 1, 1, 0, 0, 3'b000, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, "R12");
    // R2: heat arms directly
    stage(0, 1, 0, 0, 0, 3'b000, 0);
    cyc(1, 1, 0, "R2");
    // R4: set dominates clear
    stage(0, 1, 0, 1, 1, 3'b000, 0);
    cyc(1, 1, 0, "R4");
    cyc(1, 1, 0, "R4");
    // R3: one clear alone does nothing, both clear
    stage(0, 0, 0, 1, 0, 3'b000, 0);
    cyc(1, 1, 0, "R3");
    stage(0, 0, 0, 0, 1, 3'b000, 0);
    cyc(1, 1, 0, "R3");
    stage(0, 0, 0, 1, 1, 3'b000, 0);
    cyc(0, 1, 0, "R3");
    // R9: re-set inside hold window
    stage(0, 0, 0, 0, 0, 3'b000, 0);
    cyc(0, 1, 0, "R9");
    cyc(0, 1, 0, "R9");
    stage(0, 1, 0, 0, 0, 3'b000, 0);
    cyc(1, 1, 0, "R9");
    cyc(1, 1, 0, "R9");
    stage(0, 0, 0, 1, 1, 3'b000, 0);
    cyc(0, 1, 0, "R9");
    stage(0, 0, 0, 0, 0, 3'b000, 0);
    for (int j = 1; j < LH; j++) cyc(0, 1, 0, "R9");
    cyc(0, 0, 0, "R9");

    // R7: vibration drop restarts the count
    stage(1, 0, 0, 0, 0, 3'b000, 0);
    for (int i = 0; i < LV - 4; i++) cyc(0, 0, 0, "R7");
    stage(0, 0, 0, 0, 0, 3'b000, 0);
    cyc(0, 0, 0, "R7");
    stage(1, 0, 0, 0, 0, 3'b000, 0);
    for (int i = 1; i <= LV; i++) cyc(0, 0, 0, "R7");
    cyc(1, 1, 0, "R7");
    stage(0, 0, 0, 1, 1, 3'b000, 0);
    cyc(0, 1, 0, "R8");
    stage(0, 0, 0, 0, 0, 3'b000, 0);
    for (int j = 1; j < LH; j++) cyc(0, 1, 0, "R8");
    cyc(0, 0, 0, "R8");

    // R10: sequence delay and immediate drop on inhibit
    stage(0, 0, 0, 0, 0, 3'b010, 0);
    for (int i = 1; i < LS; i++) cyc(0, 0, 0, "R10");
    cyc(0, 0, 1, "R10");
    cyc(0, 0, 1, "R10");
    stage(0, 0, 0, 0, 0, 3'b010, 1);
    cyc(0, 0, 0, "R10");
    // R11: dropped request restarts
    stage(0, 0, 0, 0, 0, 3'b001, 0);
    for (int i = 0; i < LS - 3; i++) cyc(0, 0, 0, "R11");
    stage(0, 0, 0, 0, 0, 3'b000, 0);
    cyc(0, 0, 0, "R11");
    stage(0, 0, 0, 0, 0, 3'b100, 0);
    for (int i = 1; i < LS; i++) cyc(0, 0, 0, "R11");
    cyc(0, 0, 1, "R11");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule